// File: doc/BRIEF.md
# Dual-Channel High/Low Count PWM

This block produces two independent pulse-width-modulated outputs. Each channel's waveform is set by two 16-bit phase lengths: a high count and a low count, both measured in count ticks. A count tick is made by dividing one of four source strobes by a 7-bit prescaler plus one. Each period starts with the high phase and ends with the low phase, then repeats.

Software uses a plain write strobe and a combinational read port to reach three 32-bit words. There is one count word per channel and one shared control word. The control word holds, for each channel, the source select, the prescaler, a clock gate and an output enable. The four source strobes are one-cycle enables that are synchronous to `clk`, so the whole block runs in a single clock domain.

Changing a count word never cuts a period short. The new lengths are taken up at the next period boundary. Setting both the gate and the enable of a channel starts a fresh period. Clearing either of them forces the output low at once.

Top module: `dual_hl_pwm`

## Requirements
- R1: After reset all three words read as zero and both outputs are low.
- R2: Accesses are decoded by byte address, with bits [1:0] required to be zero. Address 0x0 is channel A's count word, 0x4 is channel B's count word and 0x8 is the control word. Every word reads back the full 32-bit value last written to it. Any other address reads zero, and writes to it change nothing.
- R3: In a count word, bits [31:16] give the high-phase length and bits [15:0] give the low-phase length, both in ticks.
- R4: Control word layout. Channel A uses bit 0 (enable), bits [5:4] (select), bits [14:8] (prescaler) and bit 15 (gate). Channel B uses bit 1, bits [7:6], bits [22:16] and bit 23 in the same roles. A channel runs only while its gate and its enable are both 1; otherwise its output is low.
- R5: A select value n picks `src_tick[n]`. A running channel makes one count tick for every (prescaler + 1) pulses of the selected strobe.
- R6: A period lasts high + low ticks. The output is high for the first high-count ticks and low for the rest of the period.
- R7: Suppose a write at clock edge k makes a channel run. The output stays low in the cycle after edge k. From edge k+1 the channel starts a fresh period in the high phase, with its prescaler at zero, and it counts only strobe pulses present at edges after k+1.
- R8: A control write that leaves a channel not running drives that channel's output low in the cycle right after the write edge, whatever phase the channel was in.
- R9: With a low count of 0 and a nonzero high count, the output is high for high-1 ticks and low for the last tick of the period. For example, high = 0xFFFF gives exactly one low tick per period.
- R10: With a high count of 0 the output stays low. With both counts at 0 the output also stays low.
- R11: A count word written in the middle of a period leaves that period unchanged. The new lengths apply from the next period boundary.
- R12: The two channels run independently: each has its own select, prescaler and counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for one cycle |
| wr_addr | input | 4 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| src_tick | input | 4 | Four source-rate strobes, synchronous to clk |
| pwm_out | output | 2 | Channel outputs; bit 0 is channel A, bit 1 is channel B |

## Verification
The hardest cases to reach from the ports are the ones that depend on the period boundary. One is the single low tick when the low count is zero. The other is a count word update that must wait for the period wrap. The single low tick shows only at the end of a 65535-tick period, so the stimulus runs a full maximal period with the prescaler at zero and compares every cycle across the wrap. The update is written two ticks into a six-tick period, and the expected waveform switches at the computed boundary. Small counts, prescalers and sparse strobe patterns are swept exhaustively on each channel, and the expected level is computed from the pulse count.

// File: rtl/dhl_pkg.sv
package dhl_pkg;
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int CNT_W     = 16;
    localparam int DIV_W     = 7;
    localparam int SEL_W     = 2;
    localparam int N_CH      = 2;
    localparam int N_SRC     = 1 << SEL_W;
    localparam int WORD_CTRL = N_CH;
    localparam int CTRL_OFS  = WORD_CTRL * 4;
    localparam int HI_LSB    = DATA_W - CNT_W;

    // control word field positions per channel
    function automatic int en_bit(input int ch);
        return ch;
    endfunction
    function automatic int sel_lsb(input int ch);
        return 4 + SEL_W * ch;
    endfunction
    function automatic int div_lsb(input int ch);
        return 8 + 8 * ch;
    endfunction
    function automatic int gate_bit(input int ch);
        return 15 + 8 * ch;
    endfunction

    typedef struct packed {
        logic             run;
        logic [SEL_W-1:0] sel;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } ch_cfg_t;
endpackage

// File: rtl/dhl_regfile.sv
module dhl_regfile
    import dhl_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [DATA_W-1:0]       rd_data,
    output ch_cfg_t [N_CH-1:0]      cfg
);
    typedef struct packed {
        logic [N_CH-1:0][DATA_W-1:0] cnt;
        logic [DATA_W-1:0]           ctrl;
    } rf_t;

    rf_t r_d, r_q;

    function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
        return (a[1:0] == 2'b00) && (int'(a[ADDR_W-1:2]) == idx);
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int i = 0; i < N_CH; i++) begin
                if (hit(wr_addr, i)) r_d.cnt[i] = wr_data;
            end
            if (hit(wr_addr, WORD_CTRL)) r_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < N_CH; i++) begin
            if (hit(rd_addr, i)) rd_data = r_q.cnt[i];
        end
        if (hit(rd_addr, WORD_CTRL)) rd_data = r_q.ctrl;
    end

    for (genvar g = 0; g < N_CH; g++) begin : g_cfg
        localparam int EN_B = en_bit(g);
        localparam int GT_B = gate_bit(g);
        localparam int SL_L = sel_lsb(g);
        localparam int DV_L = div_lsb(g);
        assign cfg[g] = '{
            run: r_q.ctrl[EN_B] & r_q.ctrl[GT_B],
            sel: r_q.ctrl[SL_L +: SEL_W],
            div: r_q.ctrl[DV_L +: DIV_W],
            hi:  r_q.cnt[g][HI_LSB +: CNT_W],
            lo:  r_q.cnt[g][0 +: CNT_W]
        };
    end
endmodule

// File: rtl/dhl_prescaler.sv
module dhl_prescaler
    import dhl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic [N_SRC-1:0] src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] pcnt;
    } pre_t;

    pre_t s_d, s_q;
    logic pulse;
    logic at_top;

    assign pulse  = src_tick[sel];
    assign at_top = (s_q.pcnt == div);
    assign tick   = active & pulse & at_top;

    always_comb begin
        s_d = s_q;
        if (!active) begin
            s_d.pcnt = '0;
        end else if (pulse) begin
            s_d.pcnt = at_top ? '0 : s_q.pcnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dhl_phase_gen.sv
module dhl_phase_gen
    import dhl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] hi,
    input  logic [CNT_W-1:0] lo,
    input  logic             tick,
    output logic             active,
    output logic             pwm
);
    localparam int TW = CNT_W + 1;

    typedef struct packed {
        logic             act;
        logic [TW-1:0]    cnt;
        logic [CNT_W-1:0] hi_s;
        logic [CNT_W-1:0] lo_s;
    } ph_t;

    ph_t s_d, s_q;
    logic [TW-1:0]    total;
    logic [CNT_W-1:0] hi_eff;
    logic             wrap;

    assign total  = {1'b0, s_q.hi_s} + {1'b0, s_q.lo_s};
    // a zero low count still yields one low tick at the period end
    assign hi_eff = ((s_q.lo_s == '0) && (s_q.hi_s != '0)) ? s_q.hi_s - CNT_W'(1) : s_q.hi_s;
    assign wrap   = ((s_q.cnt + TW'(1)) >= total);

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.act = 1'b0;
            s_d.cnt = '0;
        end else if (!s_q.act) begin
            s_d.act  = 1'b1;
            s_d.cnt  = '0;
            s_d.hi_s = hi;
            s_d.lo_s = lo;
        end else if (tick) begin
            if (wrap) begin
                s_d.cnt  = '0;
                s_d.hi_s = hi;
                s_d.lo_s = lo;
            end else begin
                s_d.cnt = s_q.cnt + TW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign active = s_q.act;
    assign pwm    = run & s_q.act & (s_q.cnt < {1'b0, hi_eff});
endmodule

// File: rtl/dual_hl_pwm.sv
module dual_hl_pwm
    import dhl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [N_SRC-1:0]  src_tick,
    output logic [N_CH-1:0]   pwm_out
);
    ch_cfg_t [N_CH-1:0] cfg;
    logic [N_CH-1:0]    ch_run;
    logic [N_CH-1:0]    ch_act;
    logic [N_CH-1:0]    ch_tick;

    dhl_regfile u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .cfg     (cfg)
    );

    for (genvar g = 0; g < N_CH; g++) begin : g_ch
        assign ch_run[g] = cfg[g].run;

        dhl_prescaler u_pre (
            .clk      (clk),
            .rst_n    (rst_n),
            .active   (ch_run[g] & ch_act[g]),
            .src_tick (src_tick),
            .sel      (cfg[g].sel),
            .div      (cfg[g].div),
            .tick     (ch_tick[g])
        );

        dhl_phase_gen u_ph (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (ch_run[g]),
            .hi     (cfg[g].hi),
            .lo     (cfg[g].lo),
            .tick   (ch_tick[g]),
            .active (ch_act[g]),
            .pwm    (pwm_out[g])
        );
    end
endmodule

// File: rtl/dual_hl_pwm_chk.sv
module dual_hl_pwm_chk
    import dhl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [N_CH-1:0]   run,
    input logic [N_CH-1:0]   act,
    input logic [N_CH-1:0]   tick,
    input logic [N_CH-1:0]   pwm_out
);
    AST_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) && ($past(wr_addr) == rd_addr) && (rd_addr[1:0] == 2'b00)
         && (int'(rd_addr[ADDR_W-1:2]) <= WORD_CTRL))
        |-> (rd_data == $past(wr_data))); // R2

    for (genvar c = 0; c < N_CH; c++) begin : g_a
        AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
            !run[c] |-> !pwm_out[c]); // R4

        AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            tick[c] |-> (run[c] && act[c])); // R5

        AST_CUT_NOW: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && (wr_addr == ADDR_W'(CTRL_OFS)) && !wr_data[c]) |=> !pwm_out[c]); // R8

        AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(run[c]) && run[c] && $past(act[c]) && act[c] && !$past(tick[c]))
            |-> $stable(pwm_out[c])); // R6
    end
endmodule

bind dual_hl_pwm dual_hl_pwm_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .run     (ch_run),
    .act     (ch_act),
    .tick    (ch_tick),
    .pwm_out (pwm_out)
);

// File: tb/tb_dual_hl_pwm.sv
`timescale 1ns/1ps
module tb_dual_hl_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  src_tick = '0;
    logic [1:0]  pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] hi_r [2];
    logic [15:0] lo_r [2];

    dual_hl_pwm dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .src_tick(src_tick), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
        rd_addr = a;
        #1;
        check(rd_data == exp, req, rd_data, exp);
    endtask

    task automatic set_counts(input int ch, input logic [15:0] hi, input logic [15:0] lo);
        hi_r[ch] = hi; lo_r[ch] = lo;
        wr(4'(ch * 4), {hi, lo});
    endtask

    function automatic logic [31:0] ctrl_word(input bit ea, input bit eb, input bit ga, input bit gb,
                                               input int sa, input int sb, input int da, input int db);
        logic [31:0] w = '0;
        w[0] = ea; w[1] = eb; w[15] = ga; w[23] = gb;
        w[5:4] = 2'(sa); w[7:6] = 2'(sb);
        w[14:8] = 7'(da); w[22:16] = 7'(db);
        return w;
    endfunction

    function automatic bit expv(input int hi, input int lo, input longint ticks);
        int total = hi + lo;
        int he;
        longint t;
        if (total == 0) return 1'b0;
        t  = ticks % total;
        he = (lo == 0 && hi != 0) ? hi - 1 : hi;
        return t < he;
    endfunction

    // enable with ctrl, then compare both outputs every cycle against the arithmetic model
    task automatic run_chk(input logic [31:0] ctrl, input int ncyc, input int upd_j,
                           input logic [15:0] nhi, input logic [15:0] nlo, input string req);
        longint pulses [2];
        bit en [2];
        int sel [2];
        int dv [2];
        int t0;
        for (int c = 0; c < 2; c++) begin
            en[c]  = ctrl[c] & ctrl[15 + 8 * c];
            sel[c] = int'(ctrl[4 + 2 * c +: 2]);
            dv[c]  = int'(ctrl[8 + 8 * c +: 7]);
            pulses[c] = 0;
        end
        t0 = int'(hi_r[0]) + int'(lo_r[0]);
        src_tick = '0;
        wr(4'h8, ctrl);
        check(pwm_out == 2'b00, "R7", pwm_out, 0);
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            wr_en = 1'b0;
            for (int c = 0; c < 2; c++) begin
                longint ticks = pulses[c] / (dv[c] + 1);
                bit e;
                if (!en[c]) e = 1'b0;
                else if (c == 0 && upd_j >= 0 && ticks >= t0) e = expv(int'(nhi), int'(nlo), ticks - t0);
                else e = expv(int'(hi_r[c]), int'(lo_r[c]), ticks);
                check(pwm_out[c] == e, req, pwm_out[c], e);
            end
            for (int s = 0; s < 4; s++) src_tick[s] = ((j % (s + 1)) == 0);
            for (int c = 0; c < 2; c++) if (src_tick[sel[c]]) pulses[c]++;
            if (j == upd_j) begin
                wr_en = 1'b1; wr_addr = 4'h0; wr_data = {nhi, nlo};
            end
        end
        src_tick = '0;
        if (upd_j >= 0) begin hi_r[0] = nhi; lo_r[0] = nlo; end
    endtask

    task automatic stop_chk(input string req);
        wr(4'h8, 32'h0);
        check(pwm_out == 2'b00, req, pwm_out, 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        string req;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(pwm_out == 2'b00, "R1", pwm_out, 0);
        rd_chk(4'h0, 32'h0, "R1");
        rd_chk(4'h4, 32'h0, "R1");
        rd_chk(4'h8, 32'h0, "R1");

        // R2 readback and unmapped addresses
        wr(4'h0, 32'hDEAD_BEEF);
        wr(4'h4, 32'h1234_5678);
        wr(4'h8, 32'hFFFF_FFFC);
        wr(4'hC, 32'hCAFE_F00D);
        wr(4'h1, 32'h5555_5555);
        rd_chk(4'h0, 32'hDEAD_BEEF, "R2");
        rd_chk(4'h4, 32'h1234_5678, "R2");
        rd_chk(4'h8, 32'hFFFF_FFFC, "R2");
        rd_chk(4'hC, 32'h0, "R2");
        // R4 gates set, enables clear: outputs remain low
        check(pwm_out == 2'b00, "R4", pwm_out, 0);

        // R4 enables set, gates clear
        set_counts(0, 3, 2);
        set_counts(1, 2, 2);
        run_chk(ctrl_word(1, 1, 0, 0, 0, 0, 0, 0), 20, -1, 0, 0, "R4");
        stop_chk("R8");

        // R3 field positions
        set_counts(0, 2, 6);
        rd_chk(4'h0, {16'd2, 16'd6}, "R3");
        run_chk(ctrl_word(1, 0, 1, 0, 0, 0, 0, 0), 24, -1, 0, 0, "R3");
        stop_chk("R8");

        // channel A sweep: counts, prescaler, source select
        set_counts(1, 5, 5);
        for (int h = 0; h < 4; h++)
            for (int l = 0; l < 4; l++)
                for (int d = 0; d < 3; d++)
                    for (int si = 0; si < 2; si++) begin
                        int s = si * 2;
                        req = (h == 0) ? "R10" : (l == 0) ? "R9" : (s != 0) ? "R5" : "R6";
                        set_counts(0, 16'(h), 16'(l));
                        run_chk(ctrl_word(1, 0, 1, 0, s, 0, d, 0), 48, -1, 0, 0, req);
                        stop_chk("R8");
                    end

        // channel B sweep with A idle
        for (int h = 0; h < 4; h++)
            for (int l = 1; l < 4; l++)
                for (int d = 0; d < 2; d++)
                    for (int si = 0; si < 2; si++) begin
                        int s = si * 2 + 1;
                        set_counts(1, 16'(h), 16'(l));
                        run_chk(ctrl_word(0, 1, 0, 1, 0, s, 0, d), 40, -1, 0, 0, (h == 0) ? "R10" : "R12");
                        stop_chk("R8");
                    end

        // both channels together
        set_counts(0, 2, 1);
        set_counts(1, 1, 3);
        run_chk(ctrl_word(1, 1, 1, 1, 0, 1, 0, 1), 60, -1, 0, 0, "R12");
        stop_chk("R8");

        // R11 mid-period update
        set_counts(0, 3, 3);
        run_chk(ctrl_word(1, 0, 1, 0, 0, 0, 0, 0), 30, 2, 16'd1, 16'd2, "R11");
        stop_chk("R8");

        // R8 disable during the high phase
        set_counts(0, 20, 5);
        run_chk(ctrl_word(1, 0, 1, 0, 0, 0, 0, 0), 5, -1, 0, 0, "R6");
        check(pwm_out[0] == 1'b1, "R8", pwm_out[0], 1);
        stop_chk("R8");

        // R9 maximal high with zero low: one low tick per period
        set_counts(0, 16'hFFFF, 16'h0000);
        run_chk(ctrl_word(1, 0, 1, 0, 0, 0, 0, 0), 65545, -1, 0, 0, "R9");
        stop_chk("R8");

        finish_run();
    end
endmodule